// File: doc/BRIEF.md
# Reconfiguration Handshake and Isolation Controller

This controller runs the static-side sequence for swapping a reconfigurable module. A single swap request starts it. The controller drives an active-low request to the module. It then waits for the module to answer with an active-low acknowledge while the module also reports that it is idle. Once that happens, it isolates the module's outputs from the static logic, and it holds that isolation while the new configuration is loaded.

While the module is isolated, the static side never sees the module's real outputs. Instead it sees the consumer ready indication forced low and the consumer error indication forced high, so any transfer in flight is cancelled rather than left hanging. The producer's ready indication toward the module is forced low as well.

When configuration is reported complete, the freshly loaded module is held in reset for a fixed number of cycles. Isolation is then released one cycle after that reset ends. If the module never acknowledges within a bounded wait, the controller flags a handshake timeout and returns to idle without isolating anything.

Top module: `pr_swap_ctrl`

## Requirements
- R1: After reset and whenever no swap is in progress, busy is 0, mod_reqn is 1, isolate is 0, rm_rst is 0. In this condition cons_ready_out equals rm_cons_ready, cons_error_out equals rm_cons_error, and prod_ready_to_rm equals prod_ready_in.
- R2: A swap_req sampled high while idle makes mod_reqn 0 from the next cycle. mod_reqn stays 0 until an acknowledge is accepted or the wait times out.
- R3: An acknowledge is accepted only on a clock edge where mod_ackn is 0 and rm_idle is 1 during the wait. On the cycle after acceptance, isolate is 1 and mod_reqn is back to 1. An acknowledge given while rm_idle is 0 leaves isolate at 0.
- R4: While isolate is 1, cons_ready_out is 0, cons_error_out is 1 and prod_ready_to_rm is 0, whatever the module and producer drive.
- R5: rm_rst stays 0 during isolation until cfg_done is seen, so reset is never used in place of isolation.
- R6: cfg_done sampled high while isolated and waiting makes rm_rst 1 from the next cycle, for exactly RST_CYC cycles.
- R7: isolate falls exactly one cycle after rm_rst falls.
- R8: swap_req while a swap is in progress is ignored. No second request is issued, and the controller returns to idle after the release cycle.
- R9: If no acknowledge is accepted within TIMEOUT_CYC cycles of waiting, hs_timeout pulses high for one cycle. In that same cycle the controller is idle, and isolate never rises.
- R10: busy is 1 from the cycle mod_reqn first falls until the release cycle ends, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_req | input | 1 | Start a module swap (sampled while idle) |
| cfg_done | input | 1 | New configuration finished loading |
| busy | output | 1 | Swap in progress |
| hs_timeout | output | 1 | One-cycle pulse: acknowledge never arrived |
| mod_reqn | output | 1 | Active-low quiesce request to the module |
| mod_ackn | input | 1 | Active-low acknowledge from the module |
| rm_idle | input | 1 | Module reports it is idle |
| rm_rst | output | 1 | Reset to the newly loaded module |
| isolate | output | 1 | Module outputs are replaced by safe values |
| prod_ready_in | input | 1 | Producer ready from static logic |
| prod_ready_to_rm | output | 1 | Producer ready presented to the module |
| rm_cons_ready | input | 1 | Consumer ready from the module |
| rm_cons_error | input | 1 | Consumer error from the module |
| cons_ready_out | output | 1 | Consumer ready presented to static logic |
| cons_error_out | output | 1 | Consumer error presented to static logic |

## Verification
The assertions take two things for granted about the inputs. First, the module withdraws its acknowledge once the request is withdrawn. Second, cfg_done comes only after isolation has begun. The stimulus follows both rules. It raises mod_ackn the cycle after isolation is seen, and it pulses cfg_done only while isolated. Within those limits it sweeps several combinations:
- acknowledge delays up to the last allowed wait cycle, including stalls where the acknowledge arrives while the module is not idle;
- several configuration delays;
- every combination of the three data-side signals, both while isolated and while not.

// File: rtl/pr_swap_pkg.sv
package pr_swap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_ISO  = 3'd3,
    ST_RST  = 3'd4,
    ST_REL  = 3'd5
  } swap_state_t;

  function automatic logic st_isolating(input swap_state_t s);
    return (s == ST_ISO) || (s == ST_RST) || (s == ST_REL);
  endfunction

  function automatic logic st_requesting(input swap_state_t s);
    return (s == ST_REQ) || (s == ST_WAIT);
  endfunction

endpackage

// File: rtl/pr_cycle_counter.sv
module pr_cycle_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         at_limit
);

  logic [W-1:0] cnt;

  assign at_limit = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (!at_limit)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pr_iso_gate.sv
module pr_iso_gate #(
  parameter logic SAFE_READY = 1'b0,
  parameter logic SAFE_ERROR = 1'b1
) (
  input  logic isolate,
  input  logic prod_ready_in,
  input  logic rm_cons_ready,
  input  logic rm_cons_error,
  output logic prod_ready_to_rm,
  output logic cons_ready_out,
  output logic cons_error_out
);

  always_comb begin
    if (isolate) begin
      prod_ready_to_rm = SAFE_READY;
      cons_ready_out   = SAFE_READY;
      cons_error_out   = SAFE_ERROR;
    end else begin
      prod_ready_to_rm = prod_ready_in;
      cons_ready_out   = rm_cons_ready;
      cons_error_out   = rm_cons_error;
    end
  end

endmodule

// File: rtl/pr_swap_seq.sv
module pr_swap_seq
  import pr_swap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        swap_req,
  input  logic        cfg_done,
  input  logic        mod_ackn,
  input  logic        rm_idle,
  input  logic        wait_expired,
  input  logic        hold_done,
  output swap_state_t state,
  output logic        busy,
  output logic        mod_reqn,
  output logic        isolate,
  output logic        rm_rst,
  output logic        hs_timeout
);

  swap_state_t nxt;
  logic        ack_ok;

  assign ack_ok = !mod_ackn && rm_idle;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (swap_req) nxt = ST_REQ;
      ST_REQ:  nxt = ST_WAIT;
      ST_WAIT: begin
        if (ack_ok)            nxt = ST_ISO;
        else if (wait_expired) nxt = ST_IDLE;
      end
      ST_ISO:  if (cfg_done) nxt = ST_RST;
      ST_RST:  if (hold_done) nxt = ST_REL;
      ST_REL:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      mod_reqn   <= 1'b1;
      isolate    <= 1'b0;
      rm_rst     <= 1'b0;
      hs_timeout <= 1'b0;
    end else begin
      state      <= nxt;
      busy       <= (nxt != ST_IDLE);
      mod_reqn   <= !st_requesting(nxt);
      isolate    <= st_isolating(nxt);
      rm_rst     <= (nxt == ST_RST);
      hs_timeout <= (state == ST_WAIT) && (nxt == ST_IDLE);
    end
  end

endmodule

// File: rtl/pr_swap_ctrl.sv
module pr_swap_ctrl
  import pr_swap_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int RST_CYC     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic cfg_done,
  output logic busy,
  output logic hs_timeout,
  output logic mod_reqn,
  input  logic mod_ackn,
  input  logic rm_idle,
  output logic rm_rst,
  output logic isolate,
  input  logic prod_ready_in,
  output logic prod_ready_to_rm,
  input  logic rm_cons_ready,
  input  logic rm_cons_error,
  output logic cons_ready_out,
  output logic cons_error_out
);

  localparam int TW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [TW-1:0] WAIT_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [RW-1:0] HOLD_LAST = RW'(RST_CYC - 1);

  swap_state_t state;
  logic        wait_expired;
  logic        hold_done;

  pr_cycle_counter #(.W(TW)) u_wait_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (state != ST_WAIT),
    .limit    (WAIT_LAST),
    .at_limit (wait_expired)
  );

  pr_cycle_counter #(.W(RW)) u_hold_tmr (
    .clk      (clk),
    .rst      (rst),
    .clr      (state != ST_RST),
    .limit    (HOLD_LAST),
    .at_limit (hold_done)
  );

  pr_swap_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .swap_req     (swap_req),
    .cfg_done     (cfg_done),
    .mod_ackn     (mod_ackn),
    .rm_idle      (rm_idle),
    .wait_expired (wait_expired),
    .hold_done    (hold_done),
    .state        (state),
    .busy         (busy),
    .mod_reqn     (mod_reqn),
    .isolate      (isolate),
    .rm_rst       (rm_rst),
    .hs_timeout   (hs_timeout)
  );

  pr_iso_gate u_gate (
    .isolate          (isolate),
    .prod_ready_in    (prod_ready_in),
    .rm_cons_ready    (rm_cons_ready),
    .rm_cons_error    (rm_cons_error),
    .prod_ready_to_rm (prod_ready_to_rm),
    .cons_ready_out   (cons_ready_out),
    .cons_error_out   (cons_error_out)
  );

endmodule

// File: rtl/pr_swap_chk.sv
module pr_swap_chk (
  input logic clk,
  input logic rst,
  input logic swap_req,
  input logic busy,
  input logic hs_timeout,
  input logic mod_reqn,
  input logic mod_ackn,
  input logic rm_idle,
  input logic rm_rst,
  input logic isolate,
  input logic prod_ready_to_rm,
  input logic cons_ready_out,
  input logic cons_error_out
);

  // R4
  iso_forced_chk: assert property (@(posedge clk) disable iff (rst)
    isolate |-> (!cons_ready_out && cons_error_out && !prod_ready_to_rm));

  // R5
  rst_within_iso_chk: assert property (@(posedge clk) disable iff (rst)
    rm_rst |-> isolate);

  // R3
  iso_entry_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(isolate) |-> ($past(!mod_ackn) && $past(rm_idle) && mod_reqn));

  // R7
  iso_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(isolate) |-> (!rm_rst && $past(rm_rst, 2)));

  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    hs_timeout |-> (!isolate && !busy && mod_reqn));

  // R10
  busy_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mod_reqn && !isolate));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(swap_req) && !mod_reqn));

endmodule

bind pr_swap_ctrl pr_swap_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .swap_req         (swap_req),
  .busy             (busy),
  .hs_timeout       (hs_timeout),
  .mod_reqn         (mod_reqn),
  .mod_ackn         (mod_ackn),
  .rm_idle          (rm_idle),
  .rm_rst           (rm_rst),
  .isolate          (isolate),
  .prod_ready_to_rm (prod_ready_to_rm),
  .cons_ready_out   (cons_ready_out),
  .cons_error_out   (cons_error_out)
);

// File: tb/sim_pr_swap_ctrl.sv
`timescale 1ns/1ps
module sim_pr_swap_ctrl;

  localparam int TO  = 8;
  localparam int RSC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap_req = 1'b0, cfg_done = 1'b0;
  logic mod_ackn = 1'b1, rm_idle = 1'b1;
  logic prod_ready_in = 1'b0, rm_cons_ready = 1'b0, rm_cons_error = 1'b0;
  logic busy, hs_timeout, mod_reqn, rm_rst, isolate;
  logic prod_ready_to_rm, cons_ready_out, cons_error_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pr_swap_ctrl #(.TIMEOUT_CYC(TO), .RST_CYC(RSC)) u0 (
    .clk(clk), .rst(rst), .swap_req(swap_req), .cfg_done(cfg_done),
    .busy(busy), .hs_timeout(hs_timeout), .mod_reqn(mod_reqn),
    .mod_ackn(mod_ackn), .rm_idle(rm_idle), .rm_rst(rm_rst),
    .isolate(isolate), .prod_ready_in(prod_ready_in),
    .prod_ready_to_rm(prod_ready_to_rm), .rm_cons_ready(rm_cons_ready),
    .rm_cons_error(rm_cons_error), .cons_ready_out(cons_ready_out),
    .cons_error_out(cons_error_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R1 / R4: sweep all 8 data-side patterns, one per cycle
  task automatic sweep_data(input bit iso);
    for (int p = 0; p < 8; p++) begin
      prod_ready_in = p[0];
      rm_cons_ready = p[1];
      rm_cons_error = p[2];
      #0.5;
      if (iso) begin
        chk("R4 cons_ready", cons_ready_out, 1'b0);
        chk("R4 cons_error", cons_error_out, 1'b1);
        chk("R4 prod_ready", prod_ready_to_rm, 1'b0);
      end else begin
        chk("R1 cons_ready", cons_ready_out, p[1]);
        chk("R1 cons_error", cons_error_out, p[2]);
        chk("R1 prod_ready", prod_ready_to_rm, p[0]);
      end
      step();
    end
  endtask

  task automatic do_swap(input int dly, input int cdly);
    swap_req = 1'b1;
    step();
    swap_req = 1'b0;
    chk("R2 reqn low", mod_reqn, 1'b0);
    chk("R10 busy up", busy, 1'b1);
    chk("R2 no iso yet", isolate, 1'b0);
    step();
    for (int i = 0; i < dly; i++) begin
      // odd cycles: ack while not idle must not be accepted (R3)
      mod_ackn = !(i % 2 == 1);
      rm_idle  = !(i % 2 == 1);
      step();
      chk("R3 held off", isolate, 1'b0);
      chk("R2 reqn held", mod_reqn, 1'b0);
    end
    mod_ackn = 1'b0;
    rm_idle  = 1'b1;
    step();
    mod_ackn = 1'b1;
    chk("R3 isolate", isolate, 1'b1);
    chk("R3 reqn released", mod_reqn, 1'b1);
    chk("R5 no reset", rm_rst, 1'b0);
    sweep_data(1'b1);
    for (int i = 0; i < cdly; i++) begin
      swap_req = 1'b1;
      step();
      chk("R5 no reset wait", rm_rst, 1'b0);
      chk("R8 no new req", mod_reqn, 1'b1);
      chk("R8 still iso", isolate, 1'b1);
    end
    swap_req = 1'b0;
    cfg_done = 1'b1;
    step();
    cfg_done = 1'b0;
    chk("R6 reset on", rm_rst, 1'b1);
    for (int i = 1; i < RSC; i++) begin
      step();
      chk("R6 reset held", rm_rst, 1'b1);
      chk("R6 iso held", isolate, 1'b1);
    end
    step();
    chk("R6 reset off", rm_rst, 1'b0);
    chk("R7 iso one more", isolate, 1'b1);
    chk("R10 busy release", busy, 1'b1);
    step();
    chk("R7 iso off", isolate, 1'b0);
    chk("R10 busy off", busy, 1'b0);
    chk("R8 back idle", mod_reqn, 1'b1);
  endtask

  initial begin
    int dlys[4];
    dlys[0] = 0; dlys[1] = 1; dlys[2] = 3; dlys[3] = TO - 1;
    @(negedge clk);
    step(); step();
    rst = 1'b0;
    chk("R1 busy", busy, 1'b0);
    chk("R1 reqn", mod_reqn, 1'b1);
    chk("R1 isolate", isolate, 1'b0);
    chk("R1 rm_rst", rm_rst, 1'b0);
    chk("R1 timeout", hs_timeout, 1'b0);
    sweep_data(1'b0);
    for (int a = 0; a < 4; a++)
      for (int c = 0; c < 3; c++)
        do_swap(dlys[a], c);
    // R9 timeout
    swap_req = 1'b1;
    step();
    swap_req = 1'b0;
    step();
    for (int i = 0; i < TO - 1; i++) begin
      mod_ackn = (i % 2 == 0);
      rm_idle  = 1'b0;
      step();
      chk("R9 no early timeout", hs_timeout, 1'b0);
      chk("R9 busy", busy, 1'b1);
    end
    mod_ackn = 1'b1;
    rm_idle  = 1'b1;
    step();
    chk("R9 timeout pulse", hs_timeout, 1'b1);
    chk("R9 idle", busy, 1'b0);
    chk("R9 no iso", isolate, 1'b0);
    chk("R9 reqn", mod_reqn, 1'b1);
    step();
    chk("R9 pulse ends", hs_timeout, 1'b0);
    do_swap(2, 1);
    sweep_data(1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule